// File: doc/BRIEF.md
# On-Screen Display Raster Address Generator

This block follows a raster in pixel-clock steps, driven by horizontal and vertical sync pulses. At each step it reports whether the beam is inside the on-screen text grid. When it is, it also reports which display-memory cell is under the beam and which glyph pixel (row and column) of that cell is being drawn. A downstream character generator uses the address to fetch a character code and its attribute bit, and uses the glyph coordinates to look up the pixel in its font. This block decides whether the cell is hidden or drawn inverted during the blink phase.

The grid is 24 cells wide and 12 (or 10) cells tall, and each glyph is 12 by 18 pixels. Each glyph pixel can be stretched to 1, 2 or 3 clocks wide and 1, 2 or 3 scan lines tall. The first text row has its own pair of stretch codes; all later rows share a second pair. The grid origin is set by two 6-bit start values.

A vertical sequencer steps once per line. Its states are V_WAIT, V_TOP, V_ROWS and V_DONE:
- V_WAIT is entered on vsync.
- The first hsync after vsync moves to V_ROWS when the vertical start is zero, and to V_TOP otherwise.
- V_TOP moves to V_ROWS after 2×vstart lines.
- V_ROWS moves to V_DONE after the last line of the last row.

A horizontal sequencer steps once per clock. Its states are H_DONE, H_LEFT and H_CELLS:
- Every hsync moves to H_CELLS when the horizontal start is zero, and to H_LEFT otherwise.
- H_LEFT moves to H_CELLS after 2×hstart clocks.
- H_CELLS moves to H_DONE after the last pixel of column 23.

A frame counter driven by vsync toggles the blink phase.

Top module: `osd_raster_addr`

## Requirements
- R1: While reset is held, and right after it, char_active, blink_phase, char_hide and char_invert are all 0.
- R2: Line 0 is the line that starts at the first hsync after a vsync. The grid's first scan line is line 2×vstart.
- R3: The cycle after the hsync cycle is pixel 0 of the line. The grid's first pixel is pixel 2×hstart.
- R4: A vertical stretch code of 1 gives 2 lines per glyph row, a code of 2 gives 3, and a code of 0 or 3 gives 1. Text row 0 uses vsize_first; rows 1 and up use vsize_rest.
- R5: A horizontal stretch code of 1 gives 2 clocks per glyph column, a code of 2 gives 3, and a code of 0 or 3 gives 1. Text row 0 uses hsize_first; rows 1 and up use hsize_rest.
- R6: Inside the grid, rd_addr = text_row×24 + column. glyph_row runs from 0 to 17 and glyph_col runs from 0 to 11.
- R7: With ten_rows = 1 only text rows 0–9 are active; with ten_rows = 0, rows 0–11 are active.
- R8: char_active is 0 outside the grid and whenever disp_on is 0.
- R9: blink_phase toggles after every BLINK_FAST vsync pulses when blink_slow = 0, and after every BLINK_SLOW pulses when blink_slow = 1.
- R10: An active cell with cell_attr = 1, blink_en = 1, blink_phase = 1 and reverse_en = 0 raises char_hide.
- R11: Under the same conditions with reverse_en = 1, char_invert is raised instead and char_hide stays 0.
- R12: char_hide and char_invert both stay 0 when cell_attr, blink_en or blink_phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | One-cycle line-start pulse |
| vsync | input | 1 | One-cycle frame-start pulse |
| disp_on | input | 1 | Enables the text display |
| vstart | input | 6 | Grid top, in units of 2 lines |
| hstart | input | 6 | Grid left edge, in units of 2 clocks |
| vsize_first | input | 2 | Vertical stretch code for text row 0 |
| vsize_rest | input | 2 | Vertical stretch code for rows 1 and up |
| hsize_first | input | 2 | Horizontal stretch code for text row 0 |
| hsize_rest | input | 2 | Horizontal stretch code for rows 1 and up |
| ten_rows | input | 1 | Selects 10 rows instead of 12 |
| blink_en | input | 1 | Enables blinking |
| blink_slow | input | 1 | Selects the longer blink period |
| reverse_en | input | 1 | Blink by inverting the cell instead of hiding it |
| cell_attr | input | 1 | Attribute bit of the fetched cell |
| rd_addr | output | 9 | Display-memory cell address |
| glyph_row | output | 5 | Glyph pixel row |
| glyph_col | output | 4 | Glyph pixel column |
| char_active | output | 1 | Beam is inside the grid and the display is on |
| blink_phase | output | 1 | Current blink phase |
| char_hide | output | 1 | Blank the current cell |
| char_invert | output | 1 | Invert the current cell |

## Verification
The checker watches several properties on every cycle:
- glyph_row changes only at an hsync.
- glyph_col restarts at 0 after an hsync.
- blink_phase moves only after a vsync.
- The address and glyph column stay inside the grid.
- Hide and invert are exclusive and occur only on active cells.

The exact positions of the grid edges and the stretched pixel boundaries can only be shown by the bench's scenarios. The same holds for the switch from first-row to later-row scaling, the 10-row and 12-row cut-offs and the blink periods. The bench compares each of these, cycle by cycle, against a model of the raster.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

    typedef enum logic [1:0] {
        V_WAIT,
        V_TOP,
        V_ROWS,
        V_DONE
    } vstate_t;

    typedef enum logic [1:0] {
        H_DONE,
        H_LEFT,
        H_CELLS
    } hstate_t;

    // stretch code to repeat count: 1 -> 2, 2 -> 3, otherwise 1
    function automatic logic [1:0] scale_of(input logic [1:0] code);
        case (code)
            2'd1:    scale_of = 2'd2;
            2'd2:    scale_of = 2'd3;
            default: scale_of = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/osd_vert_seq.sv
module osd_vert_seq
    import osd_raster_pkg::*;
#(
    parameter int GH       = 18,
    parameter int ROWS     = 12,
    parameter int ROWS_ALT = 10,
    localparam int RW      = $clog2(ROWS + 1),
    localparam int GRW     = $clog2(GH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync,
    input  logic           vsync,
    input  logic [5:0]     vstart,
    input  logic [1:0]     vcode_first,
    input  logic [1:0]     vcode_rest,
    input  logic           short_mode,
    output logic           in_rows,
    output logic           first_row,
    output logic [RW-1:0]  text_row,
    output logic [GRW-1:0] glyph_row
);

    vstate_t        state_q, state_d;
    logic [6:0]     line_q;
    logic [1:0]     vsub_q;
    logic [GRW-1:0] grow_q;
    logic [RW-1:0]  trow_q;
    logic [1:0]     vrep;
    logic           last_sub, last_grow, last_trow;
    int             nrows;

    assign nrows     = short_mode ? ROWS_ALT : ROWS;
    assign vrep      = scale_of((trow_q == '0) ? vcode_first : vcode_rest);
    assign last_sub  = (vsub_q == vrep - 2'd1);
    assign last_grow = (grow_q == GRW'(GH - 1));
    assign last_trow = (int'(trow_q) >= nrows - 1);

    always_comb begin
        state_d = state_q;
        if (vsync) begin
            state_d = V_WAIT;
        end else if (hsync) begin
            unique case (state_q)
                V_WAIT: state_d = (vstart == 6'd0) ? V_ROWS : V_TOP;
                V_TOP:  if (line_q + 7'd1 == {vstart, 1'b0}) state_d = V_ROWS;
                V_ROWS: if (last_sub && last_grow && last_trow) state_d = V_DONE;
                V_DONE: state_d = V_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= V_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            vsub_q <= '0;
            grow_q <= '0;
            trow_q <= '0;
        end else if (hsync && !vsync) begin
            unique case (state_q)
                V_WAIT: begin
                    line_q <= '0;
                    vsub_q <= '0;
                    grow_q <= '0;
                    trow_q <= '0;
                end
                V_TOP: line_q <= line_q + 7'd1;
                V_ROWS: begin
                    if (last_sub) begin
                        vsub_q <= '0;
                        if (last_grow) begin
                            grow_q <= '0;
                            trow_q <= trow_q + 1'b1;
                        end else begin
                            grow_q <= grow_q + 1'b1;
                        end
                    end else begin
                        vsub_q <= vsub_q + 2'd1;
                    end
                end
                V_DONE: ;
            endcase
        end
    end

    assign in_rows   = (state_q == V_ROWS);
    assign first_row = (trow_q == '0);
    assign text_row  = trow_q;
    assign glyph_row = grow_q;

endmodule

// File: rtl/osd_horiz_seq.sv
module osd_horiz_seq
    import osd_raster_pkg::*;
#(
    parameter int GW      = 12,
    parameter int COLS    = 24,
    localparam int CW     = $clog2(COLS),
    localparam int GCW    = $clog2(GW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync,
    input  logic [5:0]     hstart,
    input  logic [1:0]     hcode_first,
    input  logic [1:0]     hcode_rest,
    input  logic           first_row,
    output logic           in_cells,
    output logic [CW-1:0]  column,
    output logic [GCW-1:0] glyph_col
);

    hstate_t        state_q, state_d;
    logic [6:0]     cnt_q;
    logic [1:0]     hsub_q;
    logic [GCW-1:0] gcol_q;
    logic [CW-1:0]  col_q;
    logic [1:0]     hrep;
    logic           last_sub, last_gcol, last_col;

    assign hrep      = scale_of(first_row ? hcode_first : hcode_rest);
    assign last_sub  = (hsub_q == hrep - 2'd1);
    assign last_gcol = (gcol_q == GCW'(GW - 1));
    assign last_col  = (col_q == CW'(COLS - 1));

    always_comb begin
        state_d = state_q;
        if (hsync) begin
            state_d = (hstart == 6'd0) ? H_CELLS : H_LEFT;
        end else begin
            unique case (state_q)
                H_LEFT:  if (cnt_q + 7'd1 == {hstart, 1'b0}) state_d = H_CELLS;
                H_CELLS: if (last_sub && last_gcol && last_col) state_d = H_DONE;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= H_DONE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            cnt_q  <= '0;
            hsub_q <= '0;
            gcol_q <= '0;
            col_q  <= '0;
        end else begin
            unique case (state_q)
                H_LEFT: cnt_q <= cnt_q + 7'd1;
                H_CELLS: begin
                    if (last_sub) begin
                        hsub_q <= '0;
                        if (last_gcol) begin
                            gcol_q <= '0;
                            col_q  <= col_q + 1'b1;
                        end else begin
                            gcol_q <= gcol_q + 1'b1;
                        end
                    end else begin
                        hsub_q <= hsub_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign in_cells  = (state_q == H_CELLS);
    assign column    = col_q;
    assign glyph_col = gcol_q;

endmodule

// File: rtl/osd_blink_gen.sv
module osd_blink_gen #(
    parameter int BLINK_FAST = 15,
    parameter int BLINK_SLOW = 30,
    localparam int LIM_MAX   = (BLINK_SLOW > BLINK_FAST) ? BLINK_SLOW : BLINK_FAST,
    localparam int BW        = $clog2(LIM_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic slow_sel,
    output logic phase
);

    logic [BW-1:0] cnt_q;
    logic          phase_q;
    int            limit;

    assign limit = slow_sel ? BLINK_SLOW : BLINK_FAST;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (vsync) begin
            if (int'(cnt_q) + 1 >= limit) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/osd_raster_addr.sv
module osd_raster_addr #(
    parameter int COLS       = 24,
    parameter int ROWS       = 12,
    parameter int ROWS_ALT   = 10,
    parameter int GW         = 12,
    parameter int GH         = 18,
    parameter int BLINK_FAST = 15,
    parameter int BLINK_SLOW = 30,
    localparam int AW        = $clog2(COLS * ROWS),
    localparam int RW        = $clog2(ROWS + 1),
    localparam int CW        = $clog2(COLS),
    localparam int GRW       = $clog2(GH),
    localparam int GCW       = $clog2(GW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync,
    input  logic           vsync,
    input  logic           disp_on,
    input  logic [5:0]     vstart,
    input  logic [5:0]     hstart,
    input  logic [1:0]     vsize_first,
    input  logic [1:0]     vsize_rest,
    input  logic [1:0]     hsize_first,
    input  logic [1:0]     hsize_rest,
    input  logic           ten_rows,
    input  logic           blink_en,
    input  logic           blink_slow,
    input  logic           reverse_en,
    input  logic           cell_attr,
    output logic [AW-1:0]  rd_addr,
    output logic [GRW-1:0] glyph_row,
    output logic [GCW-1:0] glyph_col,
    output logic           char_active,
    output logic           blink_phase,
    output logic           char_hide,
    output logic           char_invert
);

    logic          in_rows, in_cells, first_row, blink_now;
    logic [RW-1:0] text_row;
    logic [CW-1:0] column;

    osd_vert_seq #(.GH(GH), .ROWS(ROWS), .ROWS_ALT(ROWS_ALT)) u_vert (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .vstart(vstart), .vcode_first(vsize_first), .vcode_rest(vsize_rest),
        .short_mode(ten_rows), .in_rows(in_rows), .first_row(first_row),
        .text_row(text_row), .glyph_row(glyph_row)
    );

    osd_horiz_seq #(.GW(GW), .COLS(COLS)) u_horiz (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .hstart(hstart),
        .hcode_first(hsize_first), .hcode_rest(hsize_rest),
        .first_row(first_row), .in_cells(in_cells), .column(column),
        .glyph_col(glyph_col)
    );

    osd_blink_gen #(.BLINK_FAST(BLINK_FAST), .BLINK_SLOW(BLINK_SLOW)) u_blink (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .slow_sel(blink_slow),
        .phase(blink_phase)
    );

    assign rd_addr     = AW'(text_row) * AW'(COLS) + AW'(column);
    assign char_active = disp_on && in_rows && in_cells;
    assign blink_now   = char_active && blink_en && cell_attr && blink_phase;
    assign char_hide   = blink_now && !reverse_en;
    assign char_invert = blink_now && reverse_en;

endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
    parameter int COLS = 24,
    parameter int ROWS = 12,
    parameter int GW   = 12,
    parameter int AW   = 9,
    parameter int GRW  = 5,
    parameter int GCW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hsync,
    input logic           vsync,
    input logic [AW-1:0]  rd_addr,
    input logic [GRW-1:0] glyph_row,
    input logic [GCW-1:0] glyph_col,
    input logic           char_active,
    input logic           blink_phase,
    input logic           char_hide,
    input logic           char_invert
);

    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync |=> $stable(glyph_row));

    // R3
    col_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (glyph_col == '0));

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_active |-> (int'(rd_addr) < COLS * ROWS && int'(glyph_col) < GW));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(blink_phase));

    // R11
    hide_inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({char_hide, char_invert}));

    // R8
    blink_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_hide || char_invert) |-> char_active);

endmodule

bind osd_raster_addr osd_raster_chk #(
    .COLS(COLS), .ROWS(ROWS), .GW(GW), .AW(AW), .GRW(GRW), .GCW(GCW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .rd_addr(rd_addr), .glyph_row(glyph_row), .glyph_col(glyph_col),
    .char_active(char_active), .blink_phase(blink_phase),
    .char_hide(char_hide), .char_invert(char_invert)
);

// File: tb/osd_raster_addr_bench.sv
module osd_raster_addr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // vector table: start positions, stretch codes, row mode, lines and line length
    localparam int T_HS  [NVEC] = '{0, 3, 5, 63, 0, 0};
    localparam int T_VS  [NVEC] = '{0, 2, 1, 0, 0, 0};
    localparam int T_HC0 [NVEC] = '{0, 1, 3, 0, 0, 0};
    localparam int T_HC1 [NVEC] = '{0, 2, 0, 0, 0, 0};
    localparam int T_VC0 [NVEC] = '{0, 2, 3, 0, 0, 0};
    localparam int T_VC1 [NVEC] = '{0, 1, 2, 0, 0, 0};
    localparam int T_TEN [NVEC] = '{0, 0, 0, 0, 1, 0};
    localparam int T_NL  [NVEC] = '{22, 64, 26, 20, 184, 220};
    localparam int T_LL  [NVEC] = '{292, 874, 302, 418, 4, 4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0, vsync = 1'b0, disp_on = 1'b0;
    logic [5:0] vstart = '0, hstart = '0;
    logic [1:0] vsize_first = '0, vsize_rest = '0, hsize_first = '0, hsize_rest = '0;
    logic       ten_rows = 1'b0, blink_en = 1'b0, blink_slow = 1'b0;
    logic       reverse_en = 1'b0, cell_attr = 1'b0;
    logic [8:0] rd_addr;
    logic [4:0] glyph_row;
    logic [3:0] glyph_col;
    logic       char_active, blink_phase, char_hide, char_invert;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    osd_raster_addr #(.BLINK_FAST(2), .BLINK_SLOW(3)) u_osd_raster_addr (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .disp_on(disp_on), .vstart(vstart), .hstart(hstart),
        .vsize_first(vsize_first), .vsize_rest(vsize_rest),
        .hsize_first(hsize_first), .hsize_rest(hsize_rest),
        .ten_rows(ten_rows), .blink_en(blink_en), .blink_slow(blink_slow),
        .reverse_en(reverse_en), .cell_attr(cell_attr), .rd_addr(rd_addr),
        .glyph_row(glyph_row), .glyph_col(glyph_col),
        .char_active(char_active), .blink_phase(blink_phase),
        .char_hide(char_hide), .char_invert(char_invert)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sc(input int code);
        return (code == 1) ? 2 : (code == 2) ? 3 : 1;
    endfunction

    // raster model built from the requirements
    task automatic model(input int L, input int c, output bit act,
                         output int addr, output int gr, output int gc);
        int d, vr0, vr1, nrows, trow, hr, e, col;
        act = 0; addr = 0; gr = 0; gc = 0;
        vr0 = sc(vsize_first); vr1 = sc(vsize_rest);
        nrows = ten_rows ? 10 : 12;
        if (!disp_on || L < 2 * vstart) return;
        d = L - 2 * vstart;
        if (d < 18 * vr0) begin
            trow = 0; gr = d / vr0;
        end else begin
            d = d - 18 * vr0;
            trow = 1 + d / (18 * vr1);
            gr = (d % (18 * vr1)) / vr1;
        end
        if (trow >= nrows || c < 2 * hstart) return;
        e = c - 2 * hstart;
        hr = (trow == 0) ? sc(hsize_first) : sc(hsize_rest);
        if (e >= 24 * 12 * hr) return;
        col = e / (12 * hr);
        gc = (e % (12 * hr)) / hr;
        addr = trow * 24 + col;
        act = 1;
    endtask

    task automatic pulse_h();
        @(negedge clk) hsync = 1'b1;
        @(negedge clk) hsync = 1'b0;
    endtask

    task automatic pulse_v();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        bit ea;
        int eaddr, egr, egc;

        repeat (2) @(negedge clk);
        // R1: state held in and just after reset
        check("R1 active", char_active, 0);
        check("R1 phase", blink_phase, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 active after", char_active, 0);
        check("R1 hide/invert", {char_hide, char_invert}, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 against the raster model
        disp_on = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            hstart = 6'(T_HS[v]);      vstart = 6'(T_VS[v]);
            hsize_first = 2'(T_HC0[v]); hsize_rest = 2'(T_HC1[v]);
            vsize_first = 2'(T_VC0[v]); vsize_rest = 2'(T_VC1[v]);
            ten_rows = T_TEN[v][0];
            pulse_v();
            for (int L = 0; L < T_NL[v]; L++) begin
                pulse_h();
                for (int c = 0; c < T_LL[v]; c++) begin
                    if (c > 0) @(negedge clk);
                    model(L, c, ea, eaddr, egr, egc);
                    check("R2 R3 R7 R8 active", char_active, ea);
                    if (ea && char_active) begin
                        check("R6 addr", rd_addr, eaddr);
                        check("R4 glyph_row", glyph_row, egr);
                        check("R5 glyph_col", glyph_col, egc);
                    end
                end
            end
        end

        // blink and attribute directed tests
        do_reset();
        disp_on = 1'b1; hstart = '0; vstart = '0; ten_rows = 1'b0;
        vsize_first = '0; vsize_rest = '0; hsize_first = '0; hsize_rest = '0;
        blink_slow = 1'b0;
        pulse_v();
        check("R9 fast one", blink_phase, 0);
        pulse_v();
        check("R9 fast toggle", blink_phase, 1);
        pulse_h();
        check("R8 active cell", char_active, 1);
        cell_attr = 1'b1; blink_en = 1'b1; reverse_en = 1'b0; #1;
        check("R10 hide", {char_hide, char_invert}, 2);
        reverse_en = 1'b1; #1;
        check("R11 invert", {char_hide, char_invert}, 1);
        blink_en = 1'b0; #1;
        check("R12 blink off", {char_hide, char_invert}, 0);
        blink_en = 1'b1; cell_attr = 1'b0; #1;
        check("R12 attr off", {char_hide, char_invert}, 0);
        cell_attr = 1'b1; disp_on = 1'b0; #1;
        check("R8 display off", char_active, 0);
        check("R8 display off hide", {char_hide, char_invert}, 0);
        disp_on = 1'b1; reverse_en = 1'b0;
        pulse_v();
        pulse_v();
        check("R9 fast back", blink_phase, 0);
        pulse_h();
        check("R12 phase low", {char_hide, char_invert}, 0);
        blink_slow = 1'b1;
        pulse_v();
        pulse_v();
        check("R9 slow hold", blink_phase, 0);
        pulse_v();
        check("R9 slow toggle", blink_phase, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule